// File: doc/BRIEF.md
# Linear Frequency Sweep Phase Accumulator

This block is the numeric core of a direct digital synthesizer with a linear frequency ramp. A tuning word register feeds a phase accumulator that adds the tuning word on every clock, wrapping modulo 2^W. When ramping is enabled, a rate timer counts down from a programmed interval. Each time it expires, the tuning word moves by a programmed step towards a bound. The bound is the upper word when the direction input is 1 and the lower word when it is 0.

A ramp starts on a restart strobe or on any change of the direction input. A restart strobe reloads the tuning word with the opposite bound before ramping. A direction change keeps the current tuning word and ramps from there in the new direction. When the next step would cross the bound, the tuning word lands exactly on the bound and the ramp ends. What happens after that depends on a control bit sampled at completion. With the bit at 0 the final frequency keeps running. With the bit at 1 the accumulator is zeroed and held at zero until the next ramp start. A separate clear input zeroes the accumulator for as long as it is high. All configuration arrives as parallel inputs.

Top module: `sweep_phase_acc`

## Requirements
- R1: During reset `phase_acc` and `ftw_out` are 0, and no ramp is active.
- R2: While `phase_clr` is 1, `phase_acc` is 0 after every clock edge. Once it returns to 0, each following edge adds `ftw_out` to the accumulator.
- R3: While `sweep_en` is 0, `ftw_out` takes `lo_ftw` one edge later, no ramp runs, and `clear_at_end` has no effect: the accumulator keeps adding.
- R4: With `sweep_en` at 1, a `restart` pulse loads `ftw_out` on the same edge. It loads `lo_ftw` if `dir_up` is 1 and `hi_ftw` if `dir_up` is 0.
- R5: After a start, the first step is applied `ramp_interval`+1 edges later, and every further step comes `ramp_interval`+1 edges after the previous one. Each step adds `ramp_step` when ramping up and subtracts it when ramping down.
- R6: When a step would pass the bound (`hi_ftw` going up, `lo_ftw` going down), `ftw_out` is set to that bound instead, and the ramp ends.
- R7: If `clear_at_end` was 0 at completion, `ftw_out` stays at the bound and the accumulator keeps advancing by that value.
- R8: If `clear_at_end` was 1 at completion, `phase_acc` is 0 from the following edge on and stays 0 while no new ramp starts.
- R9: After completion, `ftw_out` changes only on a `restart` pulse or on a change of `dir_up`. A change of `dir_up` ramps from the current `ftw_out` in the new direction.
- R10: A ramp start lifts the hold from R8 on the start edge. `phase_acc` reads 0 after that edge and the restarted tuning word after the next edge.
- R11: The accumulator wraps modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sweep_en | input | 1 | Enable the linear ramp (0: fixed tone at lo_ftw) |
| clear_at_end | input | 1 | Zero and hold the accumulator once a ramp completes |
| phase_clr | input | 1 | Force the accumulator to zero while high |
| restart | input | 1 | One-cycle strobe that reloads the start word and begins a ramp |
| dir_up | input | 1 | Ramp direction, 1 up and 0 down; any change starts a ramp |
| lo_ftw | input | W | Lower tuning word bound |
| hi_ftw | input | W | Upper tuning word bound |
| ramp_step | input | W | Tuning word increment per timer expiry |
| ramp_interval | input | RATE_W | Rate timer reload; the period is this value plus one |
| phase_acc | output | W | Accumulated phase word |
| ftw_out | output | W | Current tuning word |

## Verification
The assertions assume that all inputs are synchronous to `clk` and settle between edges. They also assume that a ramp's bounds satisfy `lo_ftw` ≤ `hi_ftw`. Under that assumption an idle ramp can only be disturbed by a strobe or a direction change. The stimulus changes every input on the falling edge only. It keeps the lower bound strictly below the upper bound and uses a nonzero step. It holds the bounds steady for the whole of each ramp, so completion points and held values can be predicted edge by edge.

// File: rtl/sweep_phase_acc.sv
module sweep_phase_acc #(
  parameter int W      = 32,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sweep_en,
  input  logic              clear_at_end,
  input  logic              phase_clr,
  input  logic              restart,
  input  logic              dir_up,
  input  logic [W-1:0]      lo_ftw,
  input  logic [W-1:0]      hi_ftw,
  input  logic [W-1:0]      ramp_step,
  input  logic [RATE_W-1:0] ramp_interval,
  output logic [W-1:0]      phase_acc,
  output logic [W-1:0]      ftw_out
);

  logic [RATE_W-1:0] tmr;
  logic              ramping;
  logic              end_clr;
  logic              dir_q;

  logic              start;
  logic              expire;
  logic [W-1:0]      gap_up, gap_dn;
  logic              last_up, last_dn, last_step;
  logic [W-1:0]      bound;

  assign start     = restart | (dir_up != dir_q);
  assign expire    = ramping && (tmr == '0);
  assign gap_up    = hi_ftw - ftw_out;
  assign gap_dn    = ftw_out - lo_ftw;
  assign last_up   = (ftw_out >= hi_ftw) || (gap_up < ramp_step);
  assign last_dn   = (ftw_out <= lo_ftw) || (gap_dn < ramp_step);
  assign last_step = dir_q ? last_up : last_dn;
  assign bound     = dir_q ? hi_ftw : lo_ftw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ftw_out <= '0;
      tmr     <= '0;
      ramping <= 1'b0;
      end_clr <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      dir_q <= dir_up;
      if (!sweep_en) begin
        ftw_out <= lo_ftw;
        tmr     <= '0;
        ramping <= 1'b0;
        end_clr <= 1'b0;
      end else if (start) begin
        if (restart) ftw_out <= dir_up ? lo_ftw : hi_ftw;
        tmr     <= ramp_interval;
        ramping <= 1'b1;
        end_clr <= 1'b0;
      end else if (expire) begin
        if (last_step) begin
          ftw_out <= bound;
          ramping <= 1'b0;
          end_clr <= clear_at_end;
        end else begin
          ftw_out <= dir_q ? ftw_out + ramp_step : ftw_out - ramp_step;
          tmr     <= ramp_interval;
        end
      end else if (ramping) begin
        tmr <= tmr - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || phase_clr || end_clr) phase_acc <= '0;
    else                                phase_acc <= phase_acc + ftw_out;
  end

  // R2
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |=> (phase_acc == '0));

  // R3
  fixed_tone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sweep_en |=> (ftw_out == $past(lo_ftw)));

  // R3
  nodwell_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sweep_en |=> !end_clr);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_en && !ramping && !start) |=> $stable(ftw_out));

  // R8
  ramp_or_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ramping, end_clr}));

  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_en && start) |=> (ramping && !end_clr));

endmodule

// File: tb/sweep_phase_acc_test.sv
`timescale 1ns/1ps
module sweep_phase_acc_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        sweep_en = 0, clear_at_end = 0, phase_clr = 0, restart = 0, dir_up = 0;
  logic [31:0] lo_ftw = 0, hi_ftw = 0, ramp_step = 0;
  logic [15:0] ramp_interval = 0;
  logic [31:0] phase_acc, ftw_out;
  logic [31:0] p;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sweep_phase_acc uut (
    .clk(clk), .rst_n(rst_n), .sweep_en(sweep_en), .clear_at_end(clear_at_end),
    .phase_clr(phase_clr), .restart(restart), .dir_up(dir_up),
    .lo_ftw(lo_ftw), .hi_ftw(hi_ftw), .ramp_step(ramp_step),
    .ramp_interval(ramp_interval), .phase_acc(phase_acc), .ftw_out(ftw_out));

  // {tone word, edges accumulated, expected phase}
  localparam logic [95:0] VEC [4] = '{
    {32'h0000_1000, 32'd5,  32'h0000_5000},
    {32'h4000_0000, 32'd7,  32'hC000_0000},
    {32'hFFFF_FFFF, 32'd3,  32'hFFFF_FFFD},
    {32'd12345,     32'd10, 32'd123450}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 phase", phase_acc, 0);
    chk("R1 ftw", ftw_out, 0);
    rst_n = 1;

    for (int i = 0; i < 4; i++) begin
      lo_ftw = VEC[i][95:64];
      phase_clr = 1;
      tick(2);
      chk("R2 cleared", phase_acc, 0);
      phase_clr = 0;
      tick(int'(VEC[i][63:32]));
      chk("R11 phase", phase_acc, VEC[i][31:0]);
      chk("R3 tone", ftw_out, VEC[i][95:64]);
    end

    lo_ftw = 100; hi_ftw = 200; ramp_step = 30; ramp_interval = 2;
    sweep_en = 1; restart = 1; dir_up = 1;
    tick(1); restart = 0;
    chk("R4 up load", ftw_out, 100);
    tick(2);
    chk("R5 no step yet", ftw_out, 100);
    tick(1);
    chk("R5 first step", ftw_out, 130);
    tick(9);
    chk("R6 saturate up", ftw_out, 200);
    tick(8);
    chk("R7 hold end", ftw_out, 200);
    p = phase_acc; tick(1);
    chk("R7 runs", phase_acc - p, 200);

    clear_at_end = 1; dir_up = 0;
    tick(1);
    chk("R9 keep word", ftw_out, 200);
    tick(3);
    chk("R9 down step", ftw_out, 170);
    tick(9);
    chk("R6 saturate down", ftw_out, 100);
    tick(1);
    chk("R8 cleared", phase_acc, 0);
    tick(7);
    chk("R8 held", phase_acc, 0);
    chk("R9 no restart", ftw_out, 100);
    restart = 1;
    tick(1); restart = 0;
    chk("R4 down load", ftw_out, 200);
    chk("R10 start edge", phase_acc, 0);
    tick(1);
    chk("R10 resumed", phase_acc, 200);

    sweep_en = 0; clear_at_end = 1; lo_ftw = 77;
    tick(2);
    chk("R3 tone", ftw_out, 77);
    p = phase_acc; tick(1);
    chk("R3 no-dwell ignored", phase_acc - p, 77);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule